// File: doc/BRIEF.md
# Synthesizer Divider Configuration Register

This block holds the settings of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test code. These are the active settings. Two loading paths share them. The parallel path copies dedicated divider pins into the active settings while an active-low load strobe is low, and keeps the last copied values once the strobe returns high. The serial path shifts a 14-bit frame in on a slow serial clock and moves it into the active settings on a separate load strobe. While that strobe stays high, the block runs in a pass-through mode: every new serial bit reaches the feedback divide value at once.

The strobes, the serial clock and all data pins are asynchronous to the system clock. They pass through one shared synchronizer, so pin data and strobe edges stay aligned, and every edge is detected in the system clock domain. An input change reaches the outputs a fixed few system clocks later. A flag output reports when the active feedback divide value lies outside the lock range of the synthesizer's loop. The shift register's oldest bit is driven out for test use.

Top module: `synth_div_cfg`

## Requirements
- R1: After reset, act_m is 511, act_n is 2'b11, act_t is 3'b000, and the shift register is all zero, so shift_out is 0.
- R2: While par_load_n is low, act_m and act_n follow par_m and par_n, act_t is 0, and ser_clk and ser_load have no effect on the active values or on the shift register.
- R3: When par_load_n goes high, the last pin values seen while it was low stay in act_m and act_n. Later changes on par_m and par_n are ignored.
- R4: While par_load_n is high, each rising ser_clk shifts ser_data into bit 0 of the 14-bit shift register. shift_out is bit 13, the oldest bit.
- R5: The first of 14 shifted bits becomes act_t[2]. The bits that follow fill act_t[1], act_t[0], act_n[1], act_n[0], then act_m[8] down to act_m[0].
- R6: While par_load_n is high, a rising ser_load copies the whole shift register into act_t, act_n and act_m.
- R7: While par_load_n is high and ser_load is low, the active values do not change, whatever ser_clk, ser_data, par_m or par_n do.
- R8: While ser_load stays high and par_load_n is high, each rising ser_clk loads act_m with the low 9 bits of the newly shifted register. act_n and act_t keep their values.
- R9: m_out_of_range is high exactly when act_m is below 125 or above 360. Both limits are parameters.
- R10: If a ser_clk rise and a ser_load rise fall in the same cycle, the transfer includes the bit shifted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel load strobe, active low |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock, edge-detected |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial transfer and pass-through strobe |
| act_m | output | 9 | Active feedback divide value |
| act_n | output | 2 | Active output divide code |
| act_t | output | 3 | Active test code |
| shift_out | output | 1 | Oldest bit of the shift register |
| m_out_of_range | output | 1 | act_m lies outside the lock range |

## Verification
A shift and a transfer can land in the same system clock cycle. This happens when the final frame bit's ser_clk rise and the ser_load rise pass through the synchronizer together. The bench provokes this by raising both pins on the same falling clock edge. It judges the result by expecting the active settings to equal the complete 14-bit frame, last bit included. A shift and a pass-through update of act_m also coincide on every serial clock rise while ser_load is high. There the bench expects act_m to carry the bit just shifted.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int FRAME_W = T_W + N_W + M_W;

  // Packed so that the earliest shifted bit lands in the top of t.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } div_cfg_t;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES:0][W-1:0] chain;

  assign chain[0] = d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= RST_VAL;
      else        chain[g+1] <= chain[g];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/sdc_rise_det.sv
module sdc_rise_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/sdc_shifter.sv
module sdc_shifter
  import sdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               sd,
  output logic [FRAME_W-1:0] sr_q,
  output logic [FRAME_W-1:0] sr_next
);
  logic [FRAME_W-1:0] sr_shifted;

  always_comb begin
    sr_shifted = {sr_q[FRAME_W-2:0], sd};
    sr_next    = shift_en ? sr_shifted : sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= sr_shifted;
  end

  // R4: no shift without a qualified serial clock rise
  p_sr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
  // R4: newest bit enters at position 0
  p_sr_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(sd));
endmodule

// File: rtl/sdc_cfg_regs.sv
module sdc_cfg_regs
  import sdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pl_n_s,
  input  logic [M_W-1:0]     pm_s,
  input  logic [N_W-1:0]     pn_s,
  input  logic               sld_s,
  input  logic               sld_rise,
  input  logic               sck_rise,
  input  logic [FRAME_W-1:0] sr_next,
  output div_cfg_t           act_q
);
  localparam div_cfg_t RST_CFG = '{t: '0, n: '1, m: '1};

  div_cfg_t sr_cfg;
  div_cfg_t act_d;
  logic     act_en;

  assign sr_cfg = div_cfg_t'(sr_next);

  always_comb begin
    act_d  = act_q;
    act_en = 1'b0;
    if (!pl_n_s) begin
      act_d.m = pm_s;
      act_d.n = pn_s;
      act_d.t = '0;
      act_en  = 1'b1;
    end else if (sld_rise) begin
      act_d  = sr_cfg;
      act_en = 1'b1;
    end else if (sld_s && sck_rise) begin
      act_d.m = sr_cfg.m;
      act_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= RST_CFG;
    else if (act_en) act_q <= act_d;
  end

  // R2: parallel mode forces the test code to zero
  p_par_test_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_n_s |=> act_q.t == '0);
  // R2: parallel mode follows the pins
  p_par_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_n_s |=> (act_q.m == $past(pm_s)) && (act_q.n == $past(pn_s)));
  // R6 / R10: transfer takes the shifter's value of that cycle
  p_transfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_n_s && sld_rise) |=> act_q == $past(sr_next));
  // R7: latched settings hold while serial load is low
  p_latched_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_n_s && !sld_s) |=> $stable(act_q));
  // R8: pass-through updates only the feedback value
  p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_n_s && sld_s && !sld_rise && sck_rise) |=>
      (act_q.m == $past(sr_next[M_W-1:0])) && $stable(act_q.n) && $stable(act_q.t));
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg
  import sdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_LO        = 125,
  parameter int M_HI        = 360
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] act_m,
  output logic [N_W-1:0] act_n,
  output logic [T_W-1:0] act_t,
  output logic           shift_out,
  output logic           m_out_of_range
);
  localparam int              IN_W   = 4 + M_W + N_W;
  localparam logic [IN_W-1:0] IN_RST = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [M_W-1:0]  LO_V   = M_W'(M_LO);
  localparam logic [M_W-1:0]  HI_V   = M_W'(M_HI);

  logic [IN_W-1:0]    raw_in;
  logic [IN_W-1:0]    syn_in;
  logic               pl_n_s, sld_s, sck_s, sd_s;
  logic [M_W-1:0]     pm_s;
  logic [N_W-1:0]     pn_s;
  logic [1:0]         rises;
  logic               sld_rise, sck_rise, shift_en;
  logic [FRAME_W-1:0] sr_q, sr_next;
  div_cfg_t           act_q;

  assign raw_in = {par_load_n, ser_load, ser_clk, ser_data, par_m, par_n};

  sdc_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  assign pl_n_s = syn_in[IN_W-1];
  assign sld_s  = syn_in[IN_W-2];
  assign sck_s  = syn_in[IN_W-3];
  assign sd_s   = syn_in[IN_W-4];
  assign pm_s   = syn_in[N_W +: M_W];
  assign pn_s   = syn_in[0 +: N_W];

  sdc_rise_det #(.W(2)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({sld_s, sck_s}),
    .rise  (rises)
  );

  assign sld_rise = rises[1];
  assign sck_rise = rises[0];
  assign shift_en = sck_rise & pl_n_s;

  sdc_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sd       (sd_s),
    .sr_q     (sr_q),
    .sr_next  (sr_next)
  );

  sdc_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .pl_n_s   (pl_n_s),
    .pm_s     (pm_s),
    .pn_s     (pn_s),
    .sld_s    (sld_s),
    .sld_rise (sld_rise),
    .sck_rise (sck_rise),
    .sr_next  (sr_next),
    .act_q    (act_q)
  );

  assign act_m          = act_q.m;
  assign act_n          = act_q.n;
  assign act_t          = act_q.t;
  assign shift_out      = sr_q[FRAME_W-1];
  assign m_out_of_range = (act_q.m < LO_V) || (act_q.m > HI_V);
endmodule

// File: tb/synth_div_cfg_tb.sv
module synth_div_cfg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_load_n, ser_clk, ser_data, ser_load;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic [8:0] act_m;
  logic [1:0] act_n;
  logic [2:0] act_t;
  logic       shift_out, m_out_of_range;

  logic [8:0]  e_m;
  logic [1:0]  e_n;
  logic [2:0]  e_t;
  logic [13:0] e_sr;
  bit          pl_lo, sld_hi;
  int          n_run = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_div_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
    .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .act_m(act_m), .act_n(act_n), .act_t(act_t), .shift_out(shift_out),
    .m_out_of_range(m_out_of_range)
  );

  function automatic logic flag_of(logic [8:0] m);
    return (m < 9'd125) || (m > 9'd360);
  endfunction

  task automatic check(string tag);
    n_run++;
    if (act_m !== e_m || act_n !== e_n || act_t !== e_t ||
        shift_out !== e_sr[13] || m_out_of_range !== flag_of(e_m)) begin
      n_fail++;
      $display("FAIL %s: got m=%0d n=%0d t=%0d so=%0b flag=%0b, want m=%0d n=%0d t=%0d so=%0b flag=%0b",
               tag, act_m, act_n, act_t, shift_out, m_out_of_range,
               e_m, e_n, e_t, e_sr[13], flag_of(e_m));
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic drive_pins(logic [8:0] m, logic [1:0] n);
    par_m = m; par_n = n;
    settle();
    if (pl_lo) begin e_m = m; e_n = n; end
  endtask

  task automatic par_low();
    par_load_n = 1'b0;
    settle();
    pl_lo = 1'b1; e_m = par_m; e_n = par_n; e_t = 3'd0;
  endtask

  task automatic par_high();
    par_load_n = 1'b1;
    settle();
    pl_lo = 1'b0;
  endtask

  task automatic clk_bit(logic b, bit with_load);
    ser_data = b;
    ser_clk  = 1'b1;
    if (with_load) ser_load = 1'b1;
    settle();
    if (!pl_lo) begin
      e_sr = {e_sr[12:0], b};
      if (with_load && !sld_hi) {e_t, e_n, e_m} = e_sr;
      else if (sld_hi)          e_m = e_sr[8:0];
    end
    if (with_load) sld_hi = 1'b1;
    ser_clk = 1'b0;
    settle();
  endtask

  task automatic load_up();
    ser_load = 1'b1;
    settle();
    if (!pl_lo && !sld_hi) {e_t, e_n, e_m} = e_sr;
    sld_hi = 1'b1;
  endtask

  task automatic load_down();
    ser_load = 1'b0;
    settle();
    sld_hi = 1'b0;
  endtask

  task automatic send_frame(logic [2:0] t, logic [1:0] n, logic [8:0] m, bit last_with_load);
    logic [13:0] f;
    f = {t, n, m};
    for (int i = 13; i >= 0; i--) clk_bit(f[i], last_with_load && (i == 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got no finish, want finish before limit");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; par_load_n = 1'b1; ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    par_m = 9'd0; par_n = 2'd0;
    e_m = 9'h1FF; e_n = 2'b11; e_t = 3'd0; e_sr = '0; pl_lo = 0; sld_hi = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R1 reset values, R9 flag at 511");

    // R1: cleared shift register shows up as all-zero transfer
    load_up();
    check("R1 R6 transfer of cleared shift register");
    load_down();

    // R2 / R3 parallel path
    drive_pins(9'd200, 2'd1);
    par_low();
    check("R2 parallel transparent");
    drive_pins(9'd300, 2'd2);
    check("R2 parallel follows pin change");
    clk_bit(1'b1, 1'b0);
    load_up();
    check("R2 serial strobes ignored in parallel mode");
    load_down();
    par_high();
    check("R3 captured on parallel rise");
    drive_pins(9'd50, 2'd3);
    check("R3 pin change after capture ignored");

    // R4 / R5 / R6 / R7 serial path
    send_frame(3'd5, 2'd2, 9'd360, 1'b0);
    check("R4 R7 frame shifted, active unchanged");
    load_up();
    check("R5 R6 frame order after transfer, R9 upper bound");
    load_down();
    drive_pins(9'd17, 2'd0);
    clk_bit(1'b0, 1'b0);
    clk_bit(1'b1, 1'b0);
    check("R7 latched against pins and serial clock");

    send_frame(3'd0, 2'd1, 9'd361, 1'b0); load_up();
    check("R9 above upper limit"); load_down();
    send_frame(3'd2, 2'd0, 9'd125, 1'b0); load_up();
    check("R9 lower bound in range"); load_down();
    send_frame(3'd7, 2'd3, 9'd124, 1'b0); load_up();
    check("R9 below lower limit"); load_down();

    // R8 pass-through
    load_up();
    for (int i = 0; i < 4; i++) begin
      clk_bit(1'(i % 2), 1'b0);
      check("R8 pass-through bit");
    end
    load_down();

    // R10 coincident shift and transfer
    send_frame(3'd6, 2'd1, 9'd301, 1'b1);
    check("R10 transfer includes coincident bit");
    load_down();

    // random mix
    for (int it = 0; it < 30; it++) begin
      case ($urandom_range(0, 3))
        0: begin
          drive_pins(9'($urandom_range(0, 511)), 2'($urandom_range(0, 3)));
          par_low();
          check("R2 random parallel");
          drive_pins(9'($urandom_range(0, 511)), 2'($urandom_range(0, 3)));
          par_high();
          drive_pins(9'($urandom_range(0, 511)), 2'($urandom_range(0, 3)));
          check("R3 random hold after capture");
        end
        1: begin
          send_frame(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                     9'($urandom_range(0, 511)), 1'b0);
          load_up();
          check("R6 random transfer");
          load_down();
        end
        2: begin
          load_up();
          for (int k = 0; k < 3; k++) begin
            clk_bit(1'($urandom_range(0, 1)), 1'b0);
            check("R8 random pass-through");
          end
          load_down();
        end
        default: begin
          drive_pins(9'($urandom_range(0, 511)), 2'($urandom_range(0, 3)));
          clk_bit(1'($urandom_range(0, 1)), 1'b0);
          check("R7 random hold");
        end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule